// File: doc/BRIEF.md
# I2C Multi-Master Arbitration Monitor

This block sits next to the bit shifter of an I2C master and decides, bit by bit, whether this master still owns the bus. Every bit the master transmits is compared with the sampled SDA line while SCL is high. This covers address bytes and data bytes alike, and there is no priority between masters. A released bit (1) that reads back as 0 means another master is driving the line. The monitor then releases the SDA driver in the same cycle and raises a sticky lost flag. It also asks the clock generator to keep toggling SCL until the current byte, including its acknowledge slot, has been clocked out.

The monitor also watches for conditions that must never meet during arbitration. These are a foreign START or STOP landing on one of this master's data bits, a repeated START that meets a data bit, a STOP that meets a data bit, and a repeated START that meets a STOP. Any of these raises an error pulse. Any SDA edge while SCL is high that this master did not command is reported as a bus START or bus STOP, so that surrounding logic can keep a bus-busy flag.

Inputs are sampled on the block clock. `sclRise` marks the first cycle in which `sclHigh` is 1. `sclFall` marks the first cycle in which `sclHigh` is 0. The command inputs `cmdStart`, `cmdRestart` and `cmdStop` stay high for the whole SCL period that carries the condition, through its falling edge if there is one.

Top module: `i2c_arb_monitor`

## Requirements
- R1: While SCL is high, an own bit of value 1 that meets `sdaIn` = 0 sets `sdaRelease` in that same cycle and sets `arbLost` at the next clock edge. Once `arbLost` is set, `sdaRelease` stays 1.
- R2: `arbLost` stays set until `cmdStart` or `clearLost` is high at a clock edge. A clear wins over a loss in the same cycle.
- R3: No loss is ever taken when `bitIsOwn` = 0 (for example an acknowledge driven by a slave), or from a mismatch seen while SCL is low.
- R4: A loss is detected at any bit position of any byte after a START, the second byte included.
- R5: `keepClock` rises together with `arbLost`. It falls at the edge of the ninth `sclFall` after the START or repeated START, which is the fall that closes the acknowledge slot.
- R6: An SDA edge while SCL is high during an own data bit (no command active, `arbLost` = 0) produces a one-cycle `arbError` pulse.
- R7: With `cmdRestart` active, `sdaIn` = 0 in the `sclRise` cycle, or a rising SDA edge while SCL is high, produces `arbError`. SDA high at the rise followed by a falling edge is legal.
- R8: With `cmdStop` active, a falling SDA edge while SCL is high, or `sdaIn` still 0 in the cycle before an `sclFall`, produces `arbError`. SDA low at the rise followed by a rising edge is legal.
- R9: With no command active, a falling SDA edge while SCL is high pulses `busStartSeen`, and a rising one pulses `busStopSeen`, one cycle later. The master's own conditions produce neither pulse.
- R10: Own bits that match the line, and own 0 bits, never cause a loss or an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sdaIn | input | 1 | Sampled SDA line |
| sclHigh | input | 1 | SCL line is high |
| sclRise | input | 1 | First cycle of SCL high |
| sclFall | input | 1 | First cycle of SCL low |
| bitDrive | input | 1 | Bit this master intends to put on SDA |
| bitIsOwn | input | 1 | Current bit slot is transmitted by this master |
| cmdStart | input | 1 | This master issues a START |
| cmdRestart | input | 1 | This master issues a repeated START |
| cmdStop | input | 1 | This master issues a STOP |
| clearLost | input | 1 | Clears the lost state |
| arbLost | output | 1 | Sticky arbitration-lost flag |
| sdaRelease | output | 1 | Forces the SDA driver off |
| arbError | output | 1 | Illegal-arbitration pulse |
| keepClock | output | 1 | Keep generating SCL until the byte ends |
| busStartSeen | output | 1 | Foreign START observed |
| busStopSeen | output | 1 | Foreign STOP observed |

## Verification
A loss and an illegal-collision error can fall in the same cycle. When a foreign START pulls SDA low while this master holds a released data bit, the bit mismatch and the forbidden SDA edge appear together. The bench provokes this by dropping the line in the middle of the high phase of an own 1 bit. It then expects exactly one error pulse, the lost flag, the continue-clock request and one foreign-START report. Because the error logic is gated only by the registered lost state, the loss taken in that cycle must not suppress the error.

// File: rtl/i2c_arb_pkg.sv
package i2c_arb_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClear;
    logic cntStep;
  } ctlStrobe_t;

  // line observations from datapath to control
  typedef struct packed {
    logic sdaRiseHigh;
    logic sdaFallHigh;
    logic lowAtRise;
    logic sdaQ;
    logic ackSlot;
  } lineObs_t;

endpackage

// File: rtl/i2c_arb_datapath.sv
module i2c_arb_datapath
  import i2c_arb_pkg::*;
#(
  parameter int BITS_PER_BYTE = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sdaIn,
  input  logic       sclHigh,
  input  logic       sclRise,
  input  ctlStrobe_t strobe,
  output lineObs_t   obs
);

  localparam int CNT_W = $clog2(BITS_PER_BYTE + 1);
  localparam logic [CNT_W-1:0] ACK_POS = CNT_W'(BITS_PER_BYTE);

  logic             sdaQ;
  logic             sclHighQ;
  logic [CNT_W-1:0] bitCnt;
  logic             stableHigh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sdaQ     <= 1'b1;
      sclHighQ <= 1'b0;
    end else begin
      sdaQ     <= sdaIn;
      sclHighQ <= sclHigh;
    end
  end

  // bit position within the byte; value BITS_PER_BYTE is the ACK slot
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (strobe.cntClear) begin
      bitCnt <= '0;
    end else if (strobe.cntStep) begin
      bitCnt <= (bitCnt == ACK_POS) ? '0 : bitCnt + 1'b1;
    end
  end

  assign stableHigh = sclHigh && sclHighQ;

  always_comb begin
    obs.sdaRiseHigh = stableHigh && sdaIn && !sdaQ;
    obs.sdaFallHigh = stableHigh && !sdaIn && sdaQ;
    obs.lowAtRise   = sclRise && !sdaIn;
    obs.sdaQ        = sdaQ;
    obs.ackSlot     = (bitCnt == ACK_POS);
  end

endmodule

// File: rtl/i2c_arb_control.sv
module i2c_arb_control
  import i2c_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sdaIn,
  input  logic       sclHigh,
  input  logic       sclFall,
  input  logic       bitDrive,
  input  logic       bitIsOwn,
  input  logic       cmdStart,
  input  logic       cmdRestart,
  input  logic       cmdStop,
  input  logic       clearLost,
  input  lineObs_t   obs,
  output ctlStrobe_t strobe,
  output logic       arbLost,
  output logic       sdaRelease,
  output logic       arbError,
  output logic       keepClock,
  output logic       busStartSeen,
  output logic       busStopSeen
);

  logic ownCond;
  logic checking;
  logic lostNow;
  logic byteEnd;
  logic errData;
  logic errRestart;
  logic errStop;
  logic lostQ;
  logic keepQ;
  logic errQ;
  logic startQ;
  logic stopQ;
  logic wipe;

  assign ownCond  = cmdStart || cmdRestart || cmdStop;
  assign checking = bitIsOwn && !lostQ && !ownCond;
  assign wipe     = clearLost || cmdStart;

  always_comb begin
    strobe.cntClear = ownCond;
    strobe.cntStep  = sclFall;
  end

  assign byteEnd    = sclFall && obs.ackSlot && !ownCond;
  assign lostNow    = checking && sclHigh && bitDrive && !sdaIn;
  assign errData    = checking && (obs.sdaRiseHigh || obs.sdaFallHigh);
  assign errRestart = cmdRestart && !lostQ && (obs.lowAtRise || obs.sdaRiseHigh);
  assign errStop    = cmdStop && !lostQ &&
                      (obs.sdaFallHigh || (sclFall && !obs.sdaQ));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lostQ  <= 1'b0;
      keepQ  <= 1'b0;
      errQ   <= 1'b0;
      startQ <= 1'b0;
      stopQ  <= 1'b0;
    end else begin
      if (wipe)         lostQ <= 1'b0;
      else if (lostNow) lostQ <= 1'b1;

      if (wipe)         keepQ <= 1'b0;
      else if (lostNow) keepQ <= 1'b1;
      else if (byteEnd) keepQ <= 1'b0;

      errQ   <= errData || errRestart || errStop;
      startQ <= obs.sdaFallHigh && !ownCond;
      stopQ  <= obs.sdaRiseHigh && !ownCond;
    end
  end

  assign arbLost      = lostQ;
  assign sdaRelease   = lostQ || lostNow;
  assign arbError     = errQ;
  assign keepClock    = keepQ;
  assign busStartSeen = startQ;
  assign busStopSeen  = stopQ;

endmodule

// File: rtl/i2c_arb_monitor.sv
module i2c_arb_monitor
  import i2c_arb_pkg::*;
#(
  parameter int BITS_PER_BYTE = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic sdaIn,
  input  logic sclHigh,
  input  logic sclRise,
  input  logic sclFall,
  input  logic bitDrive,
  input  logic bitIsOwn,
  input  logic cmdStart,
  input  logic cmdRestart,
  input  logic cmdStop,
  input  logic clearLost,
  output logic arbLost,
  output logic sdaRelease,
  output logic arbError,
  output logic keepClock,
  output logic busStartSeen,
  output logic busStopSeen
);

  ctlStrobe_t strobe;
  lineObs_t   obs;

  i2c_arb_datapath #(.BITS_PER_BYTE(BITS_PER_BYTE)) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .sdaIn  (sdaIn),
    .sclHigh(sclHigh),
    .sclRise(sclRise),
    .strobe (strobe),
    .obs    (obs)
  );

  i2c_arb_control ctl_i (
    .clk         (clk),
    .rstN        (rstN),
    .sdaIn       (sdaIn),
    .sclHigh     (sclHigh),
    .sclFall     (sclFall),
    .bitDrive    (bitDrive),
    .bitIsOwn    (bitIsOwn),
    .cmdStart    (cmdStart),
    .cmdRestart  (cmdRestart),
    .cmdStop     (cmdStop),
    .clearLost   (clearLost),
    .obs         (obs),
    .strobe      (strobe),
    .arbLost     (arbLost),
    .sdaRelease  (sdaRelease),
    .arbError    (arbError),
    .keepClock   (keepClock),
    .busStartSeen(busStartSeen),
    .busStopSeen (busStopSeen)
  );

endmodule

// File: rtl/i2c_arb_monitor_chk.sv
module i2c_arb_monitor_chk (
  input logic clk,
  input logic rstN,
  input logic sdaIn,
  input logic sclHigh,
  input logic sclFall,
  input logic bitDrive,
  input logic bitIsOwn,
  input logic cmdStart,
  input logic clearLost,
  input logic arbLost,
  input logic sdaRelease,
  input logic arbError,
  input logic keepClock,
  input logic busStartSeen,
  input logic busStopSeen
);

  // R2
  lost_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    arbLost && !clearLost && !cmdStart |=> arbLost);

  // R1
  lost_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(arbLost) |-> $past(sclHigh && bitDrive && !sdaIn));

  // R1
  release_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    arbLost |-> sdaRelease);

  // R3
  lost_own_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(arbLost) |-> $past(bitIsOwn));

  // R5
  keep_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(keepClock) |-> $rose(arbLost));

  // R5
  keep_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(keepClock) |-> $past(sclFall || cmdStart || clearLost));

  // R6
  err_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    arbError |-> $past(sclHigh || sclFall));

  // R9
  bus_flag_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busStartSeen && busStopSeen));

endmodule

bind i2c_arb_monitor i2c_arb_monitor_chk chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .sdaIn       (sdaIn),
  .sclHigh     (sclHigh),
  .sclFall     (sclFall),
  .bitDrive    (bitDrive),
  .bitIsOwn    (bitIsOwn),
  .cmdStart    (cmdStart),
  .clearLost   (clearLost),
  .arbLost     (arbLost),
  .sdaRelease  (sdaRelease),
  .arbError    (arbError),
  .keepClock   (keepClock),
  .busStartSeen(busStartSeen),
  .busStopSeen (busStopSeen)
);

// File: tb/i2c_arb_monitor_tb_top.sv
`timescale 1ns/1ps
module i2c_arb_monitor_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sdaIn = 1'b1, sclHigh = 1'b0, sclRise = 1'b0, sclFall = 1'b0;
  logic bitDrive = 1'b1, bitIsOwn = 1'b0;
  logic cmdStart = 1'b0, cmdRestart = 1'b0, cmdStop = 1'b0, clearLost = 1'b0;
  logic arbLost, sdaRelease, arbError, keepClock, busStartSeen, busStopSeen;

  int checks = 0;
  int fails = 0;
  int errCnt = 0, startCnt = 0, stopCnt = 0;
  logic relCap;

  always #2 clk = ~clk;

  i2c_arb_monitor dut_i (
    .clk(clk), .rstN(rstN), .sdaIn(sdaIn), .sclHigh(sclHigh),
    .sclRise(sclRise), .sclFall(sclFall), .bitDrive(bitDrive),
    .bitIsOwn(bitIsOwn), .cmdStart(cmdStart), .cmdRestart(cmdRestart),
    .cmdStop(cmdStop), .clearLost(clearLost), .arbLost(arbLost),
    .sdaRelease(sdaRelease), .arbError(arbError), .keepClock(keepClock),
    .busStartSeen(busStartSeen), .busStopSeen(busStopSeen)
  );

  // pulse counters: registered outputs read at the edge hold last cycle's value
  always @(posedge clk) begin
    if (rstN) begin
      if (arbError)     errCnt++;
      if (busStartSeen) startCnt++;
      if (busStopSeen)  stopCnt++;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clearCounts();
    errCnt = 0; startCnt = 0; stopCnt = 0;
  endtask

  // one bit slot: line value while SCL low and while SCL high
  task automatic slot(input bit drv, input bit own, input bit lineLow, input bit lineHigh);
    bitDrive = drv; bitIsOwn = own; sdaIn = lineLow; sclHigh = 1'b0;
    tick(2);
    sclHigh = 1'b1; sclRise = 1'b1; sdaIn = lineHigh;
    tick(1);
    sclRise = 1'b0;
    tick(1);
    relCap = sdaRelease;
    sclHigh = 1'b0; sclFall = 1'b1;
    tick(1);
    sclFall = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] drv, input logic [7:0] line);
    for (int i = 7; i >= 0; i--) slot(drv[i], 1'b1, line[i], line[i]);
  endtask

  task automatic ackSlot();
    slot(1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic ownStart();
    bitIsOwn = 1'b0; cmdStart = 1'b1; sdaIn = 1'b1; sclHigh = 1'b1;
    tick(2);
    sdaIn = 1'b0;
    tick(2);
    sclHigh = 1'b0; sclFall = 1'b1;
    tick(1);
    sclFall = 1'b0; cmdStart = 1'b0;
    tick(1);
  endtask

  // kind: 0 none, 1 repeated START, 2 STOP; l0 at rise, l1 and l2 later in high phase
  task automatic cond(input int kind, input bit l0, input bit l1, input bit l2, input bit doFall);
    bitIsOwn = 1'b0;
    cmdRestart = (kind == 1); cmdStop = (kind == 2);
    sclHigh = 1'b0; sdaIn = l0;
    tick(2);
    sclHigh = 1'b1; sclRise = 1'b1;
    tick(1);
    sclRise = 1'b0; sdaIn = l1;
    tick(2);
    sdaIn = l2;
    tick(2);
    if (doFall) begin
      sclHigh = 1'b0; sclFall = 1'b1;
      tick(1);
      sclFall = 1'b0;
    end
    cmdRestart = 1'b0; cmdStop = 1'b0;
    tick(2);
  endtask

  task automatic testReset();
    check(arbLost == 1'b0, "R2", "arbLost after reset", arbLost, 0);
    check(keepClock == 1'b0, "R5", "keepClock after reset", keepClock, 0);
    check(sdaRelease == 1'b0, "R1", "sdaRelease after reset", sdaRelease, 0);
    check(arbError == 1'b0, "R6", "arbError after reset", arbError, 0);
  endtask

  task automatic testWin();
    clearCounts();
    ownStart();
    slot(1'b1, 1'b1, 1'b1, 1'b1);
    check(relCap == 1'b0, "R10", "release on matching 1", relCap, 0);
    slot(1'b0, 1'b1, 1'b0, 1'b0);
    sendByte(8'h5A, 8'h5A);
    ackSlot();
    check(arbLost == 1'b0, "R10", "no loss on matching byte", arbLost, 0);
    check(errCnt == 0, "R10", "no error on matching byte", errCnt, 0);
  endtask

  task automatic testLoss();
    ownStart();
    slot(1'b1, 1'b1, 1'b1, 1'b1);
    slot(1'b0, 1'b1, 1'b0, 1'b0);
    slot(1'b1, 1'b1, 1'b1, 1'b1);
    slot(1'b1, 1'b1, 1'b0, 1'b0);
    check(relCap == 1'b1, "R1", "sdaRelease in losing slot", relCap, 1);
    check(arbLost == 1'b1, "R1", "arbLost after mismatch", arbLost, 1);
    check(keepClock == 1'b1, "R5", "keepClock on loss", keepClock, 1);
    for (int i = 0; i < 4; i++) slot(1'b1, 1'b1, 1'b1, 1'b1);
    check(keepClock == 1'b1, "R5", "keepClock before ACK slot", keepClock, 1);
    check(arbLost == 1'b1, "R2", "arbLost sticky over byte", arbLost, 1);
    ackSlot();
    check(keepClock == 1'b0, "R5", "keepClock after ACK fall", keepClock, 0);
    check(arbLost == 1'b1, "R2", "arbLost sticky after byte", arbLost, 1);
    clearLost = 1'b1;
    tick(1);
    clearLost = 1'b0;
    check(arbLost == 1'b0, "R2", "arbLost after clearLost", arbLost, 0);
  endtask

  task automatic testSecondByte();
    ownStart();
    sendByte(8'hC3, 8'hC3);
    ackSlot();
    check(arbLost == 1'b0, "R4", "no loss in first byte", arbLost, 0);
    sendByte(8'hFF, 8'hFB);
    check(arbLost == 1'b1, "R4", "loss in second byte", arbLost, 1);
    check(keepClock == 1'b1, "R5", "keepClock to end of second byte", keepClock, 1);
    ackSlot();
    check(keepClock == 1'b0, "R5", "keepClock after second ACK", keepClock, 0);
    ownStart();
    check(arbLost == 1'b0, "R2", "arbLost cleared by START", arbLost, 0);
  endtask

  task automatic testNotOwn();
    clearCounts();
    ownStart();
    slot(1'b1, 1'b0, 1'b0, 1'b0);
    check(arbLost == 1'b0, "R3", "slave bit mismatch ignored", arbLost, 0);
    slot(1'b1, 1'b1, 1'b0, 1'b1);
    check(arbLost == 1'b0, "R3", "low-phase mismatch ignored", arbLost, 0);
    check(errCnt == 0, "R3", "no error in ignored slots", errCnt, 0);
  endtask

  task automatic testDataCollision();
    ownStart();
    clearCounts();
    bitDrive = 1'b1; bitIsOwn = 1'b1; sdaIn = 1'b1; sclHigh = 1'b0;
    tick(2);
    sclHigh = 1'b1; sclRise = 1'b1;
    tick(1);
    sclRise = 1'b0;
    tick(1);
    sdaIn = 1'b0;
    tick(2);
    sclHigh = 1'b0; sclFall = 1'b1;
    tick(1);
    sclFall = 1'b0;
    tick(2);
    check(errCnt == 1, "R6", "error on START over data bit", errCnt, 1);
    check(arbLost == 1'b1, "R6", "loss in same cycle as error", arbLost, 1);
    check(keepClock == 1'b1, "R5", "keepClock after collision", keepClock, 1);
    check(startCnt == 1, "R9", "foreign START reported", startCnt, 1);
    clearLost = 1'b1;
    tick(1);
    clearLost = 1'b0;
  endtask

  task automatic testRestart();
    ownStart();
    clearCounts();
    cond(1, 1'b1, 1'b1, 1'b0, 1'b1);
    check(errCnt == 0, "R7", "legal repeated START", errCnt, 0);
    check(startCnt == 0, "R9", "own restart not reported", startCnt, 0);
    clearCounts();
    cond(1, 1'b0, 1'b0, 1'b0, 1'b1);
    check(errCnt == 1, "R7", "restart meets data bit", errCnt, 1);
    clearCounts();
    cond(1, 1'b0, 1'b1, 1'b1, 1'b0);
    check(errCnt > 0, "R7", "restart meets STOP", errCnt, 1);
  endtask

  task automatic testStop();
    ownStart();
    clearCounts();
    cond(2, 1'b0, 1'b0, 1'b1, 1'b0);
    check(errCnt == 0, "R8", "legal STOP", errCnt, 0);
    check(stopCnt == 0, "R9", "own STOP not reported", stopCnt, 0);
    ownStart();
    clearCounts();
    cond(2, 1'b0, 1'b0, 1'b0, 1'b1);
    check(errCnt == 1, "R8", "STOP meets data bit", errCnt, 1);
    clearCounts();
    cond(2, 1'b0, 1'b1, 1'b0, 1'b0);
    check(errCnt == 1, "R8", "STOP meets restart", errCnt, 1);
  endtask

  task automatic testForeign();
    clearCounts();
    cond(0, 1'b1, 1'b1, 1'b0, 1'b1);
    check(startCnt == 1, "R9", "foreign START pulse", startCnt, 1);
    check(stopCnt == 0, "R9", "no STOP pulse on START", stopCnt, 0);
    clearCounts();
    cond(0, 1'b0, 1'b0, 1'b1, 1'b0);
    check(stopCnt == 1, "R9", "foreign STOP pulse", stopCnt, 1);
    check(errCnt == 0, "R9", "foreign conditions no error", errCnt, 0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(2);
    testReset();
    testWin();
    testLoss();
    testSecondByte();
    testNotOwn();
    testDataCollision();
    testRestart();
    testStop();
    testForeign();
    summary();
  end

endmodule